// File: doc/BRIEF.md
# Soft Power Switch and Wake Controller

This block decides when an embedded processor's system rails may be on. It drives a single chip-select / power-enable line to an external supply. The line rises when the on-button is pressed, or when an internal wake request arrives, but only if the supply reports good power. It falls when software asks for power-down. While the system is running, software can also pulse the line low for a fixed time so that the supply latches a serial command on the falling edge.

Supply health feeds two sticky interrupt flags. Loss of power-good while the system is running sets an emergency flag, which is the high-priority path. A rising supply-status interrupt sets a routine flag, which tells software to go and read the supply's status. Software clears each flag by writing a one to it.

The switched-rail status input gates the move from waking to fully on. It also gates the return to off after a shutdown, so that the rail is known to be down before a new wake is accepted. The button, power-good, supply-interrupt and rail inputs are asynchronous and pass through a synchronizer. The button is also debounced.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `pwr_cs`, `irq_emerg` and `irq_supply` are 0 and the controller is off.
- R2: A button press wakes the system only if the synchronized button stays high for at least DB_CYCLES consecutive cycles. A shorter press leaves `pwr_cs` at 0.
- R3: While synchronized power-good is low, neither a debounced button press nor `wake_req` raises `pwr_cs`.
- R4: From off with power-good high, a one-cycle `wake_req` raises `pwr_cs` after the next clock edge.
- R5: In the waking state, synchronized rail-high moves the controller to on. Loss of power-good while waking drops `pwr_cs` and returns to off without setting the emergency flag.
- R6: A falling edge of synchronized power-good while on (including during a command strobe) sets `irq_emerg` and leaves `pwr_cs` high. The flag stays set after power-good returns.
- R7: A rising edge of the synchronized supply interrupt sets `irq_supply`. The flag stays set after the input falls.
- R8: `irq_clr[0]` clears `irq_emerg` and `irq_clr[1]` clears `irq_supply`. If a set event and a clear fall on the same edge, the flag ends set.
- R9: `sd_req` while on drops `pwr_cs` at the next edge. The controller then ignores wake requests until the synchronized rail is low, and after that returns to off.
- R10: `strobe_req` while on holds `pwr_cs` low for exactly STROBE_CYCLES cycles, then the controller returns to on. `sd_req` takes priority over `strobe_req`.
- R11: Each asynchronous input reaches the logic through SYNC_STAGES flip-flops. With two stages, the emergency flag rises on the third edge after power-good falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| btn_in | input | 1 | On-button, asynchronous, active high |
| pgood_in | input | 1 | Supply power-good status, asynchronous |
| supint_in | input | 1 | Supply status-change interrupt, asynchronous |
| rail_in | input | 1 | Switched-rail status, asynchronous |
| wake_req | input | 1 | Internal wake request, one-cycle pulse |
| sd_req | input | 1 | Software power-down request |
| strobe_req | input | 1 | Software request for a command strobe low pulse |
| irq_clr | input | 2 | Write-one-to-clear: bit 0 emergency, bit 1 supply |
| pwr_cs | output | 1 | Supply chip-select / power enable |
| irq_emerg | output | 1 | Sticky emergency flag (power-good lost while on) |
| irq_supply | output | 1 | Sticky supply-status flag |

## Verification
The bench builds the block with DB_CYCLES = 4, STROBE_CYCLES = 3 and SYNC_STAGES = 2. These values make it practical to sweep every button press length from one cycle to past the debounce threshold, and to count every cycle of the strobe pulse. The short synchronizer lets the bench predict the exact edge on which the emergency flag rises. It also lets the bench place a clear on the same edge as a set event.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;

    typedef enum logic [2:0] {
        PS_OFF      = 3'd0,
        PS_WAKING   = 3'd1,
        PS_ON       = 3'd2,
        PS_STROBE   = 3'd3,
        PS_SHUTDOWN = 3'd4
    } pwr_state_e;

    typedef struct packed {
        logic btn;
        logic pgood;
        logic supint;
        logic rail;
    } pin_set_t;

    localparam int PIN_W = $bits(pin_set_t);

    typedef struct packed {
        logic supply;
        logic emerg;
    } irq_t;

    function automatic logic cs_level(pwr_state_e s);
        return (s == PS_WAKING) || (s == PS_ON);
    endfunction

    function automatic logic is_running(pwr_state_e s);
        return (s == PS_ON) || (s == PS_STROBE);
    endfunction

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pwr_debounce.sv
module pwr_debounce #(
    parameter int DB_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic level,
    output logic rise
);
    localparam int CNT_W = $clog2(DB_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DB_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            level <= 1'b0;
            rise  <= 1'b0;
        end else begin
            rise <= 1'b0;
            if (raw != level) begin
                if (cnt == LAST) begin
                    cnt   <= '0;
                    level <= raw;
                    rise  <= raw;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import pwr_wake_pkg::*;
#(
    parameter int STROBE_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       btn_rise,
    input  logic       wake_req,
    input  logic       pg,
    input  logic       rail,
    input  logic       sd_req,
    input  logic       strobe_req,
    output pwr_state_e state
);
    localparam int SC_W = $clog2(STROBE_CYCLES + 1);
    localparam logic [SC_W-1:0] SC_LAST = SC_W'(STROBE_CYCLES - 1);

    pwr_state_e nxt;
    logic [SC_W-1:0] scnt;

    always_comb begin
        nxt = state;
        unique case (state)
            PS_OFF:      if ((btn_rise || wake_req) && pg) nxt = PS_WAKING;
            PS_WAKING:   if (!pg) nxt = PS_OFF;
                         else if (rail) nxt = PS_ON;
            PS_ON:       if (sd_req) nxt = PS_SHUTDOWN;
                         else if (strobe_req) nxt = PS_STROBE;
            PS_STROBE:   if (scnt == SC_LAST) nxt = PS_ON;
            PS_SHUTDOWN: if (!rail) nxt = PS_OFF;
            default:     nxt = PS_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PS_OFF;
            scnt  <= '0;
        end else begin
            state <= nxt;
            if (state == PS_STROBE && nxt == PS_STROBE) scnt <= scnt + 1'b1;
            else scnt <= '0;
        end
    end
endmodule

// File: rtl/pwr_irq.sv
module pwr_irq
    import pwr_wake_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pg,
    input  logic       sup,
    input  logic       running,
    input  logic [1:0] clr,
    output irq_t       flags
);
    logic pg_q, sup_q;
    logic set_emerg, set_supply;

    assign set_emerg  = pg_q && !pg && running;
    assign set_supply = sup && !sup_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pg_q  <= 1'b0;
            sup_q <= 1'b0;
            flags <= '0;
        end else begin
            pg_q  <= pg;
            sup_q <= sup;
            if (set_emerg) flags.emerg <= 1'b1;
            else if (clr[0]) flags.emerg <= 1'b0;
            if (set_supply) flags.supply <= 1'b1;
            else if (clr[1]) flags.supply <= 1'b0;
        end
    end
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
    import pwr_wake_pkg::*;
#(
    parameter int DB_CYCLES     = 1000,
    parameter int STROBE_CYCLES = 8,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       btn_in,
    input  logic       pgood_in,
    input  logic       supint_in,
    input  logic       rail_in,
    input  logic       wake_req,
    input  logic       sd_req,
    input  logic       strobe_req,
    input  logic [1:0] irq_clr,
    output logic       pwr_cs,
    output logic       irq_emerg,
    output logic       irq_supply
);
    pin_set_t   pins_raw, pins_s;
    logic       pg_s, sup_s, rail_s;
    logic       btn_level, btn_rise;
    pwr_state_e state;
    irq_t       flags;

    assign pins_raw = '{btn: btn_in, pgood: pgood_in, supint: supint_in, rail: rail_in};

    pwr_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pins_raw), .q(pins_s)
    );

    assign pg_s   = pins_s.pgood;
    assign sup_s  = pins_s.supint;
    assign rail_s = pins_s.rail;

    pwr_debounce #(.DB_CYCLES(DB_CYCLES)) u_db (
        .clk(clk), .rst(rst), .raw(pins_s.btn), .level(btn_level), .rise(btn_rise)
    );

    pwr_fsm #(.STROBE_CYCLES(STROBE_CYCLES)) u_fsm (
        .clk(clk), .rst(rst), .btn_rise(btn_rise), .wake_req(wake_req),
        .pg(pg_s), .rail(rail_s), .sd_req(sd_req), .strobe_req(strobe_req),
        .state(state)
    );

    pwr_irq u_irq (
        .clk(clk), .rst(rst), .pg(pg_s), .sup(sup_s),
        .running(is_running(state)), .clr(irq_clr), .flags(flags)
    );

    assign pwr_cs     = cs_level(state);
    assign irq_emerg  = flags.emerg;
    assign irq_supply = flags.supply;

    logic unused_level;
    assign unused_level = btn_level;
endmodule

// File: rtl/pwr_wake_chk.sv
module pwr_wake_chk
    import pwr_wake_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       pg_s,
    input logic       sup_s,
    input logic       sd_req,
    input logic [1:0] irq_clr,
    input pwr_state_e state,
    input logic       pwr_cs,
    input logic       irq_emerg,
    input logic       irq_supply
);
    // R3
    cs_needs_pgood_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_cs) |-> $past(pg_s));

    // R5
    waking_pg_loss_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PS_WAKING && !pg_s) |=> (state == PS_OFF));

    // R6
    emerg_on_pg_loss_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(pg_s) && (state == PS_ON || state == PS_STROBE)) |=> irq_emerg);

    // R8
    emerg_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_emerg && !irq_clr[0]) |=> irq_emerg);

    // R7
    supply_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sup_s) |=> irq_supply);

    // R9
    sd_drops_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PS_ON && sd_req) |=> !pwr_cs);
endmodule

bind pwr_wake_ctrl pwr_wake_chk u_chk (
    .clk(clk), .rst(rst), .pg_s(pg_s), .sup_s(sup_s), .sd_req(sd_req),
    .irq_clr(irq_clr), .state(state), .pwr_cs(pwr_cs),
    .irq_emerg(irq_emerg), .irq_supply(irq_supply)
);

// File: tb/test_pwr_wake_ctrl.sv
module test_pwr_wake_ctrl;
    localparam int DB = 4;
    localparam int SC = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn_in = 0, pgood_in = 0, supint_in = 0, rail_in = 0;
    logic wake_req = 0, sd_req = 0, strobe_req = 0;
    logic [1:0] irq_clr = 2'b00;
    logic pwr_cs, irq_emerg, irq_supply;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pwr_wake_ctrl #(.DB_CYCLES(DB), .STROBE_CYCLES(SC), .SYNC_STAGES(2)) i_pwr_wake_ctrl (
        .clk(clk), .rst(rst), .btn_in(btn_in), .pgood_in(pgood_in),
        .supint_in(supint_in), .rail_in(rail_in), .wake_req(wake_req),
        .sd_req(sd_req), .strobe_req(strobe_req), .irq_clr(irq_clr),
        .pwr_cs(pwr_cs), .irq_emerg(irq_emerg), .irq_supply(irq_supply)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_wake();
        wake_req = 1; tick(1); wake_req = 0;
    endtask

    initial begin
        tick(3);
        // R1: reset state
        chk("R1 cs", pwr_cs, 0);
        chk("R1 emerg", irq_emerg, 0);
        chk("R1 supply", irq_supply, 0);
        rst = 0;
        tick(1);
        chk("R1 cs after", pwr_cs, 0);
        pgood_in = 1;
        tick(4);

        // R2: sweep button press lengths around the debounce threshold
        for (int len = 1; len <= DB + 2; len++) begin
            btn_in = 1; tick(len); btn_in = 0;
            tick(DB + 4);
            chk($sformatf("R2 press len %0d", len), pwr_cs, (len >= DB) ? 1 : 0);
            if (pwr_cs) begin
                pgood_in = 0; tick(4);
                chk("R5 pg loss in waking", pwr_cs, 0);
                chk("R5 no emerg from waking", irq_emerg, 0);
                pgood_in = 1; tick(4);
            end
        end

        // R3: wake sources blocked while power-good low
        pgood_in = 0; tick(4);
        btn_in = 1; tick(DB + 3); btn_in = 0; tick(DB + 4);
        chk("R3 button blocked", pwr_cs, 0);
        pulse_wake(); tick(2);
        chk("R3 wake_req blocked", pwr_cs, 0);
        pgood_in = 1; tick(4);

        // R4: internal wake
        pulse_wake();
        chk("R4 wake_req", pwr_cs, 1);
        // R5: rail high completes wake
        rail_in = 1; tick(4);
        chk("R5 on", pwr_cs, 1);

        // R10: strobe pulse length
        begin
            int lows = 0;
            strobe_req = 1; tick(1); strobe_req = 0;
            for (int i = 0; i < SC + 4; i++) begin
                if (!pwr_cs) lows++;
                tick(1);
            end
            chk("R10 strobe low cycles", lows, SC);
            chk("R10 back on", pwr_cs, 1);
        end

        // R11 / R6: emergency latency and stickiness
        pgood_in = 0; tick(2);
        chk("R11 emerg not yet", irq_emerg, 0);
        tick(1);
        chk("R11 emerg on third edge", irq_emerg, 1);
        chk("R6 cs stays high", pwr_cs, 1);
        pgood_in = 1; tick(4);
        chk("R6 emerg sticky", irq_emerg, 1);
        // R8: clear emergency
        irq_clr = 2'b01; tick(1); irq_clr = 2'b00;
        chk("R8 emerg cleared", irq_emerg, 0);

        // R7: supply flag
        supint_in = 1; tick(4);
        chk("R7 supply set", irq_supply, 1);
        supint_in = 0; tick(4);
        chk("R7 supply sticky", irq_supply, 1);
        irq_clr = 2'b10; tick(1); irq_clr = 2'b00;
        chk("R8 supply cleared", irq_supply, 0);
        // R8: set wins over same-edge clear
        supint_in = 1; tick(2);
        irq_clr = 2'b10; tick(1); irq_clr = 2'b00;
        chk("R8 set beats clear", irq_supply, 1);
        supint_in = 0;
        irq_clr = 2'b10; tick(1); irq_clr = 2'b00;
        chk("R8 supply cleared again", irq_supply, 0);

        // R10: shutdown has priority over strobe
        sd_req = 1; strobe_req = 1; tick(1); sd_req = 0; strobe_req = 0;
        chk("R9 cs drops", pwr_cs, 0);
        tick(SC + 2);
        chk("R10 sd beats strobe", pwr_cs, 0);
        // R9: wake ignored while rail still high
        pulse_wake(); tick(2);
        chk("R9 wake ignored in shutdown", pwr_cs, 0);
        rail_in = 0; tick(4);
        chk("R9 off", pwr_cs, 0);
        pulse_wake();
        chk("R9 rewake after off", pwr_cs, 1);
        tick(2);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule